// File: doc/BRIEF.md
# CB Band Channel Synthesizer Divider Core

This block is the digital part of a 27 MHz citizens-band frequency synthesizer loop. It runs on one system clock. Two single-cycle enables come from the analog front end. `ref_tick` marks each cycle of the crystal reference. `vco_tick` marks each cycle of the VCO signal after it has been mixed down against that reference. A 7-bit binary channel number and a transmit select decide how far each stream is divided. The two divided event streams then go to a tri-state phase/frequency comparator. The comparator drives the charge-pump up/down requests and keeps a lock indication.

The feedback ratio comes from a computed channel table. The table follows the CB channel plan, which has irregular gaps, so the ratios are not evenly spaced. Transmit adds 91 counts to the ratio. Transmit also doubles the reference division, from 2048 to 4096, which halves the comparison step. A parameter picks either the full 40-channel set or a 22-channel variant. A code outside the selected set silences the comparator, clears lock and leaves the feedback divider at its last good ratio. Both dividers pick up a new ratio only when they reach terminal count.

Top module: `cb_pll_divider`

## Requirements
- R1: With `tx_sel` low, the spacing between `fb_pulse` events, counted in `vco_tick` cycles, is (channel frequency in kHz − 20935)/5. Examples: 1206 for channel 1, 1208 for channel 2, 1258 for channel 22, 1294 for channel 40. Channels 23, 24 and 25 give 1264, 1260 and 1262.
- R2: With `tx_sel` high, the feedback ratio is the receive ratio plus 91. Examples: 1297 for channel 1 and 1385 for channel 40.
- R3: The spacing between `ref_pulse` events is 2048 `ref_tick` cycles with `tx_sel` low and 4096 with `tx_sel` high.
- R4: `chan_code` is an unsigned binary channel number. Valid codes are 1..40, or 1..22 when `FULL_SET` is 0. For any other code, from the next cycle on, `pump_up`, `pump_dn` and `locked` are 0, and the feedback divider keeps the last valid ratio.
- R5: A change of channel or `tx_sel` takes effect only at a divider's terminal count. The period already under way keeps its length.
- R6: A reference event with no pending request raises `pump_up`. A feedback event with no pending request raises `pump_dn`. The request drops when the other event arrives. Both are never high together.
- R7: `locked` rises after 16 consecutive comparisons in which the request lasted at most `LOCK_WIN` (8) cycles. It stays high until a request exceeds that window, and then it drops in the next cycle.
- R8: While reset is active, and after reset until the first tick, all outputs are 0. Both dividers emit a pulse on their first tick after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_code | input | 7 | Binary channel number |
| tx_sel | input | 1 | 1 = transmit, 0 = receive |
| ref_tick | input | 1 | One-cycle enable per reference oscillator cycle |
| vco_tick | input | 1 | One-cycle enable per mixed-down VCO cycle |
| ref_pulse | output | 1 | Divided reference event |
| fb_pulse | output | 1 | Divided feedback event |
| pump_up | output | 1 | Charge-pump up request |
| pump_dn | output | 1 | Charge-pump down request |
| locked | output | 1 | Loop lock indication |

## Verification
Some properties are checked on every cycle by the assertions. The up and down requests never overlap. An invalid channel silences the comparator on the next cycle. An oversized request clears lock on the next cycle. A divider count never moves without a tick and never skips a step between reloads. Other behaviour only shows up in the bench scenarios. These cover the exact per-channel ratios across all 40 receive channels and a spread of transmit channels, and the held ratio for invalid codes in both channel-set variants. They also cover the deferred timing of channel and mode changes, and the lock acquisition that a bench-side loop closing around the pump requests produces.

// File: rtl/cb_synth_pkg.sv
package cb_synth_pkg;

  localparam int CODE_W   = 7;
  localparam int N_CH_ALL = 40;
  localparam int N_CH_SUB = 22;

  // Receive feedback ratio of a channel: 5 kHz steps above the mixer offset.
  // Channels 1..22 move in 10 kHz steps with an extra 10 kHz gap after
  // every fourth channel; 23..25 are out of order; 26..40 are contiguous.
  function automatic int rx_ratio(input int ch);
    int r;
    if (ch <= 22)      r = 1206 + 2 * (ch - 1) + 2 * (ch / 4);
    else if (ch == 23) r = 1264;
    else if (ch == 24) r = 1260;
    else if (ch == 25) r = 1262;
    else               r = 1266 + 2 * (ch - 26);
    return r;
  endfunction

endpackage

// File: rtl/cb_chan_rom.sv
module cb_chan_rom
  import cb_synth_pkg::*;
#(
  parameter int N_W    = 11,
  parameter int NUM_CH = 40,
  parameter int TX_OFS = 91
) (
  input  logic [CODE_W-1:0] code,
  input  logic              tx,
  output logic              valid,
  output logic [N_W-1:0]    ratio
);

  localparam int N_LO = rx_ratio(1);
  localparam int N_HI = rx_ratio(NUM_CH) + TX_OFS;

  always_comb begin
    int base;
    valid = (code >= CODE_W'(1)) && (code <= CODE_W'(NUM_CH));
    base  = rx_ratio(int'(code));
    ratio = N_W'(base + (tx ? TX_OFS : 0));
    if (valid) begin
      // R1
      range_chk: assert (int'(ratio) >= N_LO && int'(ratio) <= N_HI);
    end
  end

endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] period,
  output logic         pulse
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         pulse_q, pulse_d;
  logic         term;

  always_comb begin
    term    = tick && (cnt_q == '0);
    cnt_d   = cnt_q;
    pulse_d = term;
    if (tick) begin
      if (term) cnt_d = period - W'(1);
      else      cnt_d = cnt_q - W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

  // R1
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> ($past(tick) && $past(cnt_q) == '0));

endmodule

// File: rtl/phase_freq_det.sv
module phase_freq_det #(
  parameter int LOCK_WIN = 8,
  parameter int LOCK_CNT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ref_ev,
  input  logic fb_ev,
  output logic up,
  output logic dn,
  output logic locked
);

  localparam int WID_MAX = LOCK_WIN + 1;
  localparam int WID_W   = $clog2(WID_MAX + 1);
  localparam int STK_W   = $clog2(LOCK_CNT + 1);

  logic             up_q, up_d, dn_q, dn_d, lock_q, lock_d;
  logic [WID_W-1:0] width_q, width_d;
  logic [STK_W-1:0] streak_q, streak_d;
  logic             done, in_window;

  always_comb begin
    done      = (up_q && fb_ev) || (dn_q && ref_ev) ||
                (ref_ev && fb_ev && !up_q && !dn_q);
    in_window = (width_q <= WID_W'(LOCK_WIN));
    up_d      = up_q;
    dn_d      = dn_q;
    width_d   = width_q;
    streak_d  = streak_q;
    lock_d    = lock_q;
    if (!enable) begin
      up_d     = 1'b0;
      dn_d     = 1'b0;
      width_d  = '0;
      streak_d = '0;
      lock_d   = 1'b0;
    end else if (done) begin
      up_d    = 1'b0;
      dn_d    = 1'b0;
      width_d = '0;
      if (!in_window)                          streak_d = '0;
      else if (streak_q != STK_W'(LOCK_CNT))   streak_d = streak_q + STK_W'(1);
      if (streak_d == STK_W'(LOCK_CNT))        lock_d = 1'b1;
      else if (!in_window)                     lock_d = 1'b0;
    end else begin
      if (ref_ev && !dn_q) up_d = 1'b1;
      if (fb_ev && !up_q)  dn_d = 1'b1;
      if ((up_q || dn_q) && width_q != WID_W'(WID_MAX))
        width_d = width_q + WID_W'(1);
      if (!in_window) begin
        streak_d = '0;
        lock_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      lock_q   <= 1'b0;
      width_q  <= '0;
      streak_q <= '0;
    end else begin
      up_q     <= up_d;
      dn_q     <= dn_d;
      lock_q   <= lock_d;
      width_q  <= width_d;
      streak_q <= streak_d;
    end
  end

  assign up     = up_q;
  assign dn     = dn_q;
  assign locked = lock_q;

  // R6
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_q && dn_q));

  // R7
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (width_q > WID_W'(LOCK_WIN)) |=> !lock_q);

endmodule

// File: rtl/cb_pll_divider.sv
module cb_pll_divider
  import cb_synth_pkg::*;
#(
  parameter int REF_DIV  = 2048,
  parameter int TX_OFS   = 91,
  parameter bit FULL_SET = 1'b1,
  parameter int LOCK_WIN = 8,
  parameter int LOCK_CNT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] chan_code,
  input  logic              tx_sel,
  input  logic              ref_tick,
  input  logic              vco_tick,
  output logic              ref_pulse,
  output logic              fb_pulse,
  output logic              pump_up,
  output logic              pump_dn,
  output logic              locked
);

  localparam int NUM_CH = FULL_SET ? N_CH_ALL : N_CH_SUB;
  localparam int N_MAX  = rx_ratio(NUM_CH) + TX_OFS;
  localparam int N_W    = $clog2(N_MAX + 1);
  localparam int REF_W  = $clog2(2 * REF_DIV + 1);

  logic             rst_s1_q, rst_s2_q;
  logic             chan_ok;
  logic [N_W-1:0]   n_rom, n_hold_q, n_hold_d, n_use;
  logic [REF_W-1:0] ref_period;

  // reset: asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  cb_chan_rom #(.N_W(N_W), .NUM_CH(NUM_CH), .TX_OFS(TX_OFS)) u_rom (
    .code  (chan_code),
    .tx    (tx_sel),
    .valid (chan_ok),
    .ratio (n_rom)
  );

  always_comb begin
    n_hold_d = chan_ok ? n_rom : n_hold_q;
    n_use    = n_hold_d;
  end

  always_ff @(posedge clk or negedge rst_s2_q) begin
    if (!rst_s2_q) n_hold_q <= N_W'(rx_ratio(1));
    else           n_hold_q <= n_hold_d;
  end

  assign ref_period = tx_sel ? REF_W'(2 * REF_DIV) : REF_W'(REF_DIV);

  tick_divider #(.W(REF_W)) u_ref_div (
    .clk    (clk),
    .rst_n  (rst_s2_q),
    .tick   (ref_tick),
    .period (ref_period),
    .pulse  (ref_pulse)
  );

  tick_divider #(.W(N_W)) u_fb_div (
    .clk    (clk),
    .rst_n  (rst_s2_q),
    .tick   (vco_tick),
    .period (n_use),
    .pulse  (fb_pulse)
  );

  phase_freq_det #(.LOCK_WIN(LOCK_WIN), .LOCK_CNT(LOCK_CNT)) u_pfd (
    .clk    (clk),
    .rst_n  (rst_s2_q),
    .enable (chan_ok),
    .ref_ev (ref_pulse),
    .fb_ev  (fb_pulse),
    .up     (pump_up),
    .dn     (pump_dn),
    .locked (locked)
  );

  // R4
  off_chk: assert property (@(posedge clk) disable iff (!rst_s2_q)
    !chan_ok |=> (!pump_up && !pump_dn && !locked));

endmodule

// File: tb/test_cb_pll_divider.sv
`timescale 1ns/100ps
module test_cb_pll_divider;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] chan, chan_c22;
  logic       tx;
  logic       man_ref, man_vco, loop_en, loop_tick;
  logic       vco_tick;
  logic       ref_pulse, fb_pulse, pump_up, pump_dn, locked;
  logic       ref_pulse2, fb_pulse2, pump_up2, pump_dn2, locked2;
  int         n_chk = 0, n_fail = 0;

  int freq_khz [40] = '{26965, 26975, 26985, 27005, 27015, 27025, 27035, 27055,
                        27065, 27075, 27085, 27105, 27115, 27125, 27135, 27155,
                        27165, 27175, 27185, 27205, 27215, 27225, 27255, 27235,
                        27245, 27265, 27275, 27285, 27295, 27305, 27315, 27325,
                        27335, 27345, 27355, 27365, 27375, 27385, 27395, 27405};

  always #2.5 clk = ~clk;

  assign vco_tick = loop_en ? loop_tick : man_vco;

  cb_pll_divider i_cb_pll_divider (
    .clk(clk), .rst_n(rst_n), .chan_code(chan), .tx_sel(tx),
    .ref_tick(man_ref), .vco_tick(vco_tick),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .pump_up(pump_up), .pump_dn(pump_dn), .locked(locked));

  cb_pll_divider #(.FULL_SET(1'b0)) i_cb_pll_divider_c22 (
    .clk(clk), .rst_n(rst_n), .chan_code(chan_c22), .tx_sel(tx),
    .ref_tick(man_ref), .vco_tick(vco_tick),
    .ref_pulse(ref_pulse2), .fb_pulse(fb_pulse2),
    .pump_up(pump_up2), .pump_dn(pump_dn2), .locked(locked2));

  function automatic int exp_n(input int ch, input bit t);
    return (freq_khz[ch-1] - 20935) / 5 + (t ? 91 : 0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    loop_en = 1'b0; man_ref = 1'b0; man_vco = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_pulse(input int sel, input int limit, output int iv);
    logic s;
    iv = 0;
    s  = 1'b0;
    while (!s && iv < limit) begin
      @(negedge clk);
      iv++;
      case (sel)
        0:       s = ref_pulse;
        1:       s = fb_pulse;
        default: s = fb_pulse2;
      endcase
    end
  endtask

  task automatic wait_lock(output int refs);
    int c = 0;
    refs = 0;
    while (!locked && c < 45000) begin
      @(negedge clk);
      c++;
      if (ref_pulse) refs++;
    end
  endtask

  // bench-side loop: nominal-rate feedback ticks, sped up or held back by the pump
  initial begin
    int acc;
    bit t;
    acc = 0;
    loop_tick = 1'b0;
    forever begin
      @(negedge clk);
      if (loop_en) begin
        acc += 1206;
        t = (acc >= 2048);
        if (t) acc -= 2048;
        loop_tick = pump_up || (!pump_dn && t);
      end else begin
        acc = 0;
        loop_tick = 1'b0;
      end
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int iv, refs, hits;
    int txl [7] = '{1, 2, 22, 40, 23, 4, 40};
    chan = 7'd1; chan_c22 = 7'd1; tx = 1'b0;
    do_reset();

    // R8: quiet after reset, first tick yields a pulse
    chk(!ref_pulse && !fb_pulse && !pump_up && !pump_dn && !locked, "R8 idle", 0, 0);
    man_ref = 1'b1;
    @(negedge clk);
    man_ref = 1'b0;
    chk(ref_pulse, "R8 first ref tick", ref_pulse, 1);
    @(negedge clk);
    // R6: reference first raises up
    chk(pump_up && !pump_dn, "R6 up", {pump_up, pump_dn}, 2);
    man_vco = 1'b1;
    @(negedge clk);
    man_vco = 1'b0;
    @(negedge clk);
    chk(!pump_up && !pump_dn, "R6 release", {pump_up, pump_dn}, 0);

    do_reset();
    man_vco = 1'b1;
    @(negedge clk);
    man_vco = 1'b0;
    @(negedge clk);
    chk(pump_dn && !pump_up, "R6 dn", {pump_up, pump_dn}, 1);

    // R1 sweep; channel is changed at the start of each period (R5)
    do_reset();
    chan = 7'd1;
    man_vco = 1'b1;
    wait_pulse(1, 3000, iv);
    for (int k = 1; k <= 40; k++) begin
      chan = (k == 40) ? 7'd1 : 7'(k + 1);
      wait_pulse(1, 3000, iv);
      chk(iv == exp_n(k, 1'b0), $sformatf("R1 rx ch%0d", k), iv, exp_n(k, 1'b0));
    end

    // R2 transmit ratios; first period still receive ch1 (R5)
    tx = 1'b1;
    chan = 7'(txl[0]);
    wait_pulse(1, 3000, iv);
    chk(iv == exp_n(1, 1'b0), "R5 tx switch deferred", iv, exp_n(1, 1'b0));
    for (int i = 0; i < 6; i++) begin
      chan = 7'(txl[i+1]);
      wait_pulse(1, 3000, iv);
      chk(iv == exp_n(txl[i], 1'b1), $sformatf("R2 tx ch%0d", txl[i]), iv, exp_n(txl[i], 1'b1));
    end

    // R4 invalid codes keep the last valid ratio
    tx = 1'b0;
    wait_pulse(1, 3000, iv);
    chk(iv == exp_n(40, 1'b1), "R2 tx ch40", iv, exp_n(40, 1'b1));
    chan = 7'd0;
    wait_pulse(1, 3000, iv);
    chk(iv == 1294, "R1 rx ch40", iv, 1294);
    chan = 7'd41;
    wait_pulse(1, 3000, iv);
    chk(iv == 1294, "R4 code 0 hold", iv, 1294);
    chan = 7'd127;
    wait_pulse(1, 3000, iv);
    chk(iv == 1294, "R4 code 41 hold", iv, 1294);
    chan = 7'd3;
    wait_pulse(1, 3000, iv);
    chk(iv == 1294, "R4 code 127 hold", iv, 1294);
    wait_pulse(1, 3000, iv);
    chk(iv == exp_n(3, 1'b0), "R1 rx ch3 after invalid", iv, exp_n(3, 1'b0));

    // R4 22-channel variant
    do_reset();
    chan_c22 = 7'd22;
    man_vco = 1'b1;
    wait_pulse(2, 3000, iv);
    chan_c22 = 7'd23;
    wait_pulse(2, 3000, iv);
    chk(iv == 1258, "R4 variant ch22", iv, 1258);
    chan_c22 = 7'd40;
    wait_pulse(2, 3000, iv);
    chk(iv == 1258, "R4 variant code 23 hold", iv, 1258);
    chan_c22 = 7'd5;
    wait_pulse(2, 3000, iv);
    chk(iv == 1258, "R4 variant code 40 hold", iv, 1258);
    wait_pulse(2, 3000, iv);
    chk(iv == exp_n(5, 1'b0), "R4 variant ch5", iv, exp_n(5, 1'b0));
    chan_c22 = 7'd1;

    // R3 reference division, R5 deferred mode switch
    do_reset();
    chan = 7'd1; tx = 1'b0;
    man_vco = 1'b0; man_ref = 1'b1;
    wait_pulse(0, 5000, iv);
    wait_pulse(0, 5000, iv);
    chk(iv == 2048, "R3 rx ref", iv, 2048);
    tx = 1'b1;
    wait_pulse(0, 5000, iv);
    chk(iv == 2048, "R5 ref mode deferred", iv, 2048);
    wait_pulse(0, 5000, iv);
    chk(iv == 4096, "R3 tx ref", iv, 4096);
    tx = 1'b0;
    wait_pulse(0, 5000, iv);
    chk(iv == 4096, "R5 ref back deferred", iv, 4096);
    wait_pulse(0, 5000, iv);
    chk(iv == 2048, "R3 rx ref again", iv, 2048);

    // R7 lock acquisition with the bench loop closed
    do_reset();
    chan = 7'd1; tx = 1'b0;
    man_ref = 1'b1;
    loop_en = 1'b1;
    wait_lock(refs);
    chk(locked, "R7 lock reached", locked, 1);
    chk(refs >= 16, "R7 comparisons before lock", refs, 16);

    // R4 invalid code silences the comparator
    chan = 7'd0;
    @(negedge clk);
    @(negedge clk);
    chk(!pump_up && !pump_dn && !locked, "R4 off", {pump_up, pump_dn, locked}, 0);
    hits = 0;
    repeat (2200) begin
      @(negedge clk);
      if (pump_up || pump_dn || locked) hits++;
    end
    chk(hits == 0, "R4 stays off", hits, 0);
    chan = 7'd1;
    wait_lock(refs);
    chk(locked && refs >= 16, "R7 relock", refs, 16);

    // R7 lock drops once a request outlasts the window
    loop_en = 1'b0;
    man_vco = 1'b0;
    iv = 0;
    while (!pump_up && iv < 2300) begin
      @(negedge clk);
      iv++;
    end
    chk(pump_up, "R7 up after feedback loss", pump_up, 1);
    chk(locked, "R7 lock held inside window", locked, 1);
    repeat (12) @(negedge clk);
    chk(!locked, "R7 lock dropped", locked, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule